// File: doc/BRIEF.md
# Predicated Floating-Point Maximum-Number Reduction Tree

The block folds one vector register into a single floating-point scalar under maximum-number rules. The vector is split into lanes of 16, 32 or 64 bits, as chosen by a two-bit size code. Neighbouring lanes are combined two at a time, their results are combined again, and so on until one value is left. A lane is active when the predicate bit at its lowest byte is set. An inactive lane enters the tree as the canonical quiet NaN (the default NaN) of the lane width. The block can therefore serve a predicated "largest element" operation in a floating-point datapath.

At every tree node the pair selector returns the numeric operand when the other is a quiet NaN, and orders negative zero below positive zero. It turns any signalling operand, or a pair of NaNs, into a quiet NaN. With the default-NaN mode bit clear, that NaN carries the chosen operand's payload; with the bit set, it is the canonical NaN. Signalling operands raise an invalid flag, and the flags of all nodes are ORed into one invalid output for the reduction. The scalar is placed zero-extended in a 64-bit result. Size code 0 is illegal: it raises an undefined flag and returns a zero result.

A parameter can place a register after every tree level. Shorter trees are padded with delay stages, so all sizes share one latency of log2(VW/16) cycles. Without the registers the block is purely combinational. There is no handshake: a new operand may be presented on every clock. The block has no control states. Its sequencing is the fixed chain of level registers plus the delay line that carries the size code to the output select.

Top module: `fmxr_top`

## Requirements
- R1: The reduction order is a fixed pairwise tree. At each level, lanes 2k and 2k+1 are combined with lane 2k as the first operand, and the level results are combined the same way until one value remains.
- R2: If no lane is active, the result is the default NaN of the selected width and invalid is 0. The default NaN has sign 0, an all-ones exponent, a set mantissa MSB and all other mantissa bits 0 (0x7E00, 0x7FC00000, 0x7FF8000000000000).
- R3: Size codes 1, 2 and 3 select 16-, 32- and 64-bit lanes. The scalar occupies res_o[EW-1:0] and all higher bits of res_o are 0.
- R4: Size code 0 sets undef_o to 1 and forces res_o to 0 and inv_o to 0. Undef_o is 0 for every other code.
- R5: When one operand of a pair is a quiet NaN (mantissa MSB set) and the other is not a NaN, the result is the non-NaN operand.
- R6: Non-NaN operands are ordered as signed values with -0 below +0. If they are equal, the first operand is returned.
- R7: If either operand is a signalling NaN (mantissa MSB clear, mantissa nonzero), the result is a quiet NaN and that node flags invalid. With dn_i=0 the NaN is the chosen operand with its mantissa MSB set, the first signalling operand being chosen in preference to the second. With dn_i=1 it is the default NaN.
- R8: When both operands are quiet NaNs, no invalid is flagged. The result is the first operand when dn_i=0 and the default NaN when dn_i=1.
- R9: A lane's activity is read only from pred_i[lane*EW/8]. The other predicate bits of the lane have no effect.
- R10: inv_o is the OR of the invalid flags of every node in the reduction, even when a numeric value wins later in the tree.
- R11: With PIPE=1, results, inv_o and undef_o appear log2(VW/16) cycles after their operands, for every size. With PIPE=0 they are combinational. A new operand may be accepted every cycle.
- R12: While reset is asserted, res_o is 0, inv_o is 0 and undef_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vec_i | input | VW | Source vector, lane 0 in the low bits |
| pred_i | input | VW/8 | Predicate, one bit per vector byte |
| size_i | input | 2 | Lane size code: 1=16, 2=32, 3=64, 0=illegal |
| dn_i | input | 1 | Default-NaN mode: 1 returns the canonical NaN for NaN results |
| res_o | output | 64 | Reduced scalar, zero-extended |
| inv_o | output | 1 | Invalid operation seen in any node |
| undef_o | output | 1 | Illegal size code |

## Verification
With the default parameters (VW=256, PIPE=1), every result is due exactly four clock edges after its operand is applied. This holds for the 64-bit trees too, because their two levels are padded by two delay stages. The bench applies a new operand at each falling edge and pushes the reference result into a queue. Once the queue holds more than four entries, it compares the head against the outputs shortly after that falling edge. Every output is therefore compared against the operand issued four cycles earlier, with back-to-back changes of lane size and NaN mode in between.

// File: rtl/fmxr_pkg.sv
package fmxr_pkg;

    typedef enum logic [1:0] {
        SZ_BAD = 2'd0,
        SZ_H   = 2'd1,
        SZ_S   = 2'd2,
        SZ_D   = 2'd3
    } fmxr_size_e;

    // exponent field width for a lane width
    function automatic int fmxr_expw(input int ew);
        if (ew == 16) return 5;
        else if (ew == 32) return 8;
        else return 11;
    endfunction

    // canonical quiet NaN for a lane width, zero-extended to 64 bits
    function automatic logic [63:0] fmxr_dnan(input int ew);
        int xw;
        int mw;
        logic [63:0] v;
        xw = fmxr_expw(ew);
        mw = ew - 1 - xw;
        v  = ((64'd1 << xw) - 64'd1) << mw;
        v  = v | (64'd1 << (mw - 1));
        return v;
    endfunction

endpackage

// File: rtl/fmxr_node.sv
module fmxr_node
    import fmxr_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    input  logic          dn_i,
    output logic [EW-1:0] y_o,
    output logic          inv_o
);

    localparam int XW = fmxr_expw(EW);
    localparam int MW = EW - 1 - XW;
    localparam logic [63:0] DN64 = fmxr_dnan(EW);
    localparam logic [EW-1:0] DNAN = DN64[EW-1:0];
    localparam logic [EW-1:0] QBIT = EW'(1) << (MW - 1);

    logic a_nan, b_nan, a_sig, b_sig;
    logic b_wins;
    logic [EW-1:0] nan_pick;

    assign a_nan = (&a_i[EW-2:MW]) && (|a_i[MW-1:0]);
    assign b_nan = (&b_i[EW-2:MW]) && (|b_i[MW-1:0]);
    assign a_sig = a_nan && !a_i[MW-1];
    assign b_sig = b_nan && !b_i[MW-1];

    // signed ordering of numeric values, -0 below +0, ties keep a
    always_comb begin
        if (a_i[EW-1] != b_i[EW-1]) begin
            b_wins = a_i[EW-1];
        end else if (!a_i[EW-1]) begin
            b_wins = b_i[EW-2:0] > a_i[EW-2:0];
        end else begin
            b_wins = b_i[EW-2:0] < a_i[EW-2:0];
        end
    end

    always_comb begin
        if (a_sig) begin
            nan_pick = a_i;
        end else if (b_sig) begin
            nan_pick = b_i;
        end else if (a_nan) begin
            nan_pick = a_i;
        end else begin
            nan_pick = b_i;
        end
    end

    always_comb begin
        inv_o = a_sig | b_sig;
        if (a_sig || b_sig || (a_nan && b_nan)) begin
            y_o = dn_i ? DNAN : (nan_pick | QBIT);
        end else if (a_nan) begin
            y_o = b_i;
        end else if (b_nan) begin
            y_o = a_i;
        end else begin
            y_o = b_wins ? b_i : a_i;
        end
    end

endmodule

// File: rtl/fmxr_lane_mask.sv
module fmxr_lane_mask
    import fmxr_pkg::*;
#(
    parameter int VW = 256,
    parameter int EW = 32
) (
    input  logic [VW-1:0]   vec_i,
    input  logic [VW/8-1:0] pred_i,
    output logic [VW-1:0]   lanes_o
);

    localparam int NL  = VW / EW;
    localparam int BPL = EW / 8;
    localparam logic [63:0] DN64 = fmxr_dnan(EW);
    localparam logic [EW-1:0] DNAN = DN64[EW-1:0];

    logic [NL-1:0] act;
    logic          any_act;
    logic [VW-1:0] opnd;
    logic          unused_pred;

    // the bytes above a lane's lowest one do not govern it
    assign unused_pred = ^pred_i;

    for (genvar gi = 0; gi < NL; gi++) begin : g_act
        assign act[gi] = pred_i[gi*BPL];
    end

    assign any_act = |act;
    assign opnd    = any_act ? vec_i : '0;

    for (genvar gi = 0; gi < NL; gi++) begin : g_lane
        assign lanes_o[gi*EW +: EW] = act[gi] ? opnd[gi*EW +: EW] : DNAN;
    end

endmodule

// File: rtl/fmxr_tree.sv
module fmxr_tree
    import fmxr_pkg::*;
#(
    parameter int VW   = 256,
    parameter int EW   = 32,
    parameter bit PIPE = 1'b1,
    parameter int STG  = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [VW-1:0]   vec_i,
    input  logic [VW/8-1:0] pred_i,
    input  logic            dn_i,
    output logic [EW-1:0]   res_o,
    output logic            inv_o
);

    localparam int NL  = VW / EW;
    localparam int LEV = $clog2(NL);
    localparam int PAD = PIPE ? (STG - LEV) : 0;

    logic [VW-1:0] lanes;
    logic [EW-1:0] lv_out;
    logic          lv_inv;

    fmxr_lane_mask #(.VW(VW), .EW(EW)) u_mask (
        .vec_i   (vec_i),
        .pred_i  (pred_i),
        .lanes_o (lanes)
    );

    for (genvar l = 0; l < LEV; l++) begin : g_lev
        localparam int NI = NL >> l;
        localparam int NO = NI / 2;

        logic [NI*EW-1:0] cur;
        logic             cur_inv;
        logic             cur_dn;
        logic [NO*EW-1:0] nxt;
        logic [NO-1:0]    ninv;
        logic [NO*EW-1:0] q_val;
        logic             q_inv;
        logic             q_dn;

        if (l == 0) begin : g_src
            assign cur     = lanes;
            assign cur_inv = 1'b0;
            assign cur_dn  = dn_i;
        end else begin : g_src
            assign cur     = g_lev[l-1].q_val;
            assign cur_inv = g_lev[l-1].q_inv;
            assign cur_dn  = g_lev[l-1].q_dn;
        end

        for (genvar j = 0; j < NO; j++) begin : g_node
            fmxr_node #(.EW(EW)) u_node (
                .a_i   (cur[(2*j)*EW +: EW]),
                .b_i   (cur[(2*j+1)*EW +: EW]),
                .dn_i  (cur_dn),
                .y_o   (nxt[j*EW +: EW]),
                .inv_o (ninv[j])
            );
        end

        if (PIPE) begin : g_q
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    q_val <= '0;
                    q_inv <= 1'b0;
                    q_dn  <= 1'b0;
                end else begin
                    q_val <= nxt;
                    q_inv <= cur_inv | (|ninv);
                    q_dn  <= cur_dn;
                end
            end
        end else begin : g_q
            assign q_val = nxt;
            assign q_inv = cur_inv | (|ninv);
            assign q_dn  = cur_dn;
        end
    end

    if (LEV == 0) begin : g_tail
        logic unused_dn;
        assign unused_dn = dn_i;
        assign lv_out    = lanes[EW-1:0];
        assign lv_inv    = 1'b0;
    end else begin : g_tail
        logic unused_dn;
        assign unused_dn = g_lev[LEV-1].q_dn;
        assign lv_out    = g_lev[LEV-1].q_val;
        assign lv_inv    = g_lev[LEV-1].q_inv;
    end

    // delay stages so that every lane size shares one latency
    for (genvar p = 0; p < PAD; p++) begin : g_pad
        logic [EW-1:0] src_v, pv;
        logic          src_i, pi;
        if (p == 0) begin : g_src
            assign src_v = lv_out;
            assign src_i = lv_inv;
        end else begin : g_src
            assign src_v = g_pad[p-1].pv;
            assign src_i = g_pad[p-1].pi;
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                pv <= '0;
                pi <= 1'b0;
            end else begin
                pv <= src_v;
                pi <= src_i;
            end
        end
    end

    if (PAD > 0) begin : g_out
        assign res_o = g_pad[PAD-1].pv;
        assign inv_o = g_pad[PAD-1].pi;
    end else begin : g_out
        assign res_o = lv_out;
        assign inv_o = lv_inv;
    end

endmodule

// File: rtl/fmxr_top.sv
module fmxr_top
    import fmxr_pkg::*;
#(
    parameter int VW   = 256,
    parameter bit PIPE = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [VW-1:0]   vec_i,
    input  logic [VW/8-1:0] pred_i,
    input  logic [1:0]      size_i,
    input  logic            dn_i,
    output logic [63:0]     res_o,
    output logic            inv_o,
    output logic            undef_o
);

    localparam int STG = $clog2(VW / 16);
    localparam int LAT = PIPE ? STG : 0;

    logic [1:0] sz_q;

    for (genvar gs = 0; gs < 3; gs++) begin : g_sz
        localparam int EW = 16 << gs;
        logic [EW-1:0] r;
        logic          iv;
        logic [63:0]   rz;

        fmxr_tree #(.VW(VW), .EW(EW), .PIPE(PIPE), .STG(STG)) u_tree (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .vec_i  (vec_i),
            .pred_i (pred_i),
            .dn_i   (dn_i),
            .res_o  (r),
            .inv_o  (iv)
        );

        assign rz = 64'(r);
    end

    if (LAT > 0) begin : g_dly
        logic [1:0] sz_d [LAT];
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                for (int i = 0; i < LAT; i++) sz_d[i] <= SZ_D;
            end else begin
                sz_d[0] <= size_i;
                for (int i = 1; i < LAT; i++) sz_d[i] <= sz_d[i-1];
            end
        end
        assign sz_q = sz_d[LAT-1];
    end else begin : g_dly
        logic unused_clk;
        assign unused_clk = clk_i ^ rst_ni;
        assign sz_q = size_i;
    end

    always_comb begin
        res_o   = '0;
        inv_o   = 1'b0;
        undef_o = 1'b0;
        unique case (fmxr_size_e'(sz_q))
            SZ_H: begin
                res_o = g_sz[0].rz;
                inv_o = g_sz[0].iv;
            end
            SZ_S: begin
                res_o = g_sz[1].rz;
                inv_o = g_sz[1].iv;
            end
            SZ_D: begin
                res_o = g_sz[2].rz;
                inv_o = g_sz[2].iv;
            end
            SZ_BAD: begin
                undef_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fmxr_chk.sv
module fmxr_chk
    import fmxr_pkg::*;
#(
    parameter int VW   = 256,
    parameter bit PIPE = 1'b1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [VW/8-1:0] pred_i,
    input logic [1:0]      size_i,
    input logic [63:0]     res_o,
    input logic            inv_o,
    input logic            undef_o
);

    localparam int LAT = PIPE ? $clog2(VW / 16) : 0;
    localparam int PB  = VW / 8;

    logic       empty_now;
    logic [1:0] sz_q;
    logic       emp_q;

    always_comb begin
        empty_now = 1'b1;
        unique case (size_i)
            2'd1: for (int i = 0; i < PB; i += 2) if (pred_i[i]) empty_now = 1'b0;
            2'd2: for (int i = 0; i < PB; i += 4) if (pred_i[i]) empty_now = 1'b0;
            2'd3: for (int i = 0; i < PB; i += 8) if (pred_i[i]) empty_now = 1'b0;
            default: empty_now = 1'b0;
        endcase
    end

    if (LAT > 0) begin : g_dly
        logic [1:0] sd [LAT];
        logic       ed [LAT];
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                for (int i = 0; i < LAT; i++) begin
                    sd[i] <= 2'd3;
                    ed[i] <= 1'b0;
                end
            end else begin
                sd[0] <= size_i;
                ed[0] <= empty_now;
                for (int i = 1; i < LAT; i++) begin
                    sd[i] <= sd[i-1];
                    ed[i] <= ed[i-1];
                end
            end
        end
        assign sz_q  = sd[LAT-1];
        assign emp_q = ed[LAT-1];
    end else begin : g_dly
        assign sz_q  = size_i;
        assign emp_q = empty_now;
    end

    // R4
    undef_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        undef_o |-> (res_o == 64'd0 && !inv_o));

    // R4
    undef_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        undef_o == (sz_q == 2'd0));

    // R3
    upper_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sz_q == 2'd1) |-> (res_o[63:16] == 48'd0));

    // R3
    upper_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sz_q == 2'd2) |-> (res_o[63:32] == 32'd0));

    // R2
    empty_dnan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        emp_q |-> (res_o == fmxr_dnan(8 << int'(sz_q)) && !inv_o));

endmodule

bind fmxr_top fmxr_chk #(.VW(VW), .PIPE(PIPE)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pred_i  (pred_i),
    .size_i  (size_i),
    .res_o   (res_o),
    .inv_o   (inv_o),
    .undef_o (undef_o)
);

// File: tb/tb_fmxr_top.sv
`timescale 1ns/1ps
module tb_fmxr_top;

    localparam int VW  = 256;
    localparam int LAT = $clog2(VW / 16);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [VW-1:0]   vec = '0;
    logic [VW/8-1:0] pred = '0;
    logic [1:0]      size = 2'd3;
    logic            dn = 1'b0;
    logic [63:0]     res;
    logic            inv;
    logic            undef;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        inv;
        logic        ud;
        string       tag;
    } exp_t;

    exp_t eq[$];

    always #2.5 clk = ~clk;

    fmxr_top #(.VW(VW), .PIPE(1'b1)) dut (
        .clk_i (clk), .rst_ni (rst_n), .vec_i (vec), .pred_i (pred),
        .size_i (size), .dn_i (dn), .res_o (res), .inv_o (inv), .undef_o (undef)
    );

    function automatic int xw_of(input int ew);
        return (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
    endfunction

    function automatic logic [63:0] dnan_of(input int ew);
        int mw;
        mw = ew - 1 - xw_of(ew);
        return ((((64'd1 << xw_of(ew)) - 64'd1) << mw) | (64'd1 << (mw - 1)));
    endfunction

    function automatic logic [63:0] ref_max(input logic [63:0] a, input logic [63:0] b,
                                            input int ew, input logic d, output logic sig);
        int mw;
        logic [63:0] em, mm, qb, sb, pick;
        logic an, bn, asn, bsn, as_, bs_;
        mw = ew - 1 - xw_of(ew);
        em = ((64'd1 << xw_of(ew)) - 64'd1) << mw;
        mm = (64'd1 << mw) - 64'd1;
        qb = 64'd1 << (mw - 1);
        sb = 64'd1 << (ew - 1);
        an = ((a & em) == em) && ((a & mm) != 0);
        bn = ((b & em) == em) && ((b & mm) != 0);
        asn = an && ((a & qb) == 0);
        bsn = bn && ((b & qb) == 0);
        sig = asn || bsn;
        if (sig || (an && bn)) begin
            pick = asn ? a : bsn ? b : an ? a : b;
            return d ? dnan_of(ew) : (pick | qb);
        end
        if (an) return b;
        if (bn) return a;
        as_ = (a & sb) != 0;
        bs_ = (b & sb) != 0;
        if (as_ != bs_) return as_ ? b : a;
        if (!as_) return ((b & (sb - 1)) > (a & (sb - 1))) ? b : a;
        return ((b & (sb - 1)) < (a & (sb - 1))) ? b : a;
    endfunction

    function automatic void ref_reduce(input logic [VW-1:0] v, input logic [VW/8-1:0] p,
                                       input logic [1:0] s, input logic d,
                                       output logic [63:0] r, output logic iv, output logic ud);
        logic [63:0] q[$];
        logic [63:0] nq[$];
        logic [63:0] lm;
        logic sg;
        int ew;
        r = 64'd0; iv = 1'b0; ud = 1'b0;
        if (s == 2'd0) begin
            ud = 1'b1;
            return;
        end
        ew = 8 << s;
        lm = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
        for (int i = 0; i < VW / ew; i++) begin
            if (p[i*ew/8]) q.push_back(64'(v >> (i*ew)) & lm);
            else q.push_back(dnan_of(ew));
        end
        while (q.size() > 1) begin
            nq.delete();
            for (int k = 0; k < q.size(); k += 2) begin
                nq.push_back(ref_max(q[k], q[k+1], ew, d, sg));
                iv = iv | sg;
            end
            q = nq;
        end
        r = q[0];
    endfunction

    function automatic logic [63:0] rnd_elem(input int ew);
        int mw;
        logic [63:0] em, qb, lm, rv;
        mw = ew - 1 - xw_of(ew);
        em = ((64'd1 << xw_of(ew)) - 64'd1) << mw;
        qb = 64'd1 << (mw - 1);
        lm = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
        rv = {$urandom, $urandom};
        case ($urandom % 10)
            0: return 64'd0;
            1: return 64'd1 << (ew - 1);
            2: return em | qb | (rv & (qb - 1));
            3: return em | ((rv & (qb - 1)) | 64'd1);
            4: return em | ((rv & 64'd1) << (ew - 1));
            default: return rv & lm;
        endcase
    endfunction

    function automatic logic [VW-1:0] rnd_vec(input int ew);
        logic [VW-1:0] v;
        v = '0;
        for (int i = 0; i < VW / ew; i++) v = v | (VW'(rnd_elem(ew)) << (i*ew));
        return v;
    endfunction

    function automatic logic [VW-1:0] set_lane(input logic [VW-1:0] v, input int ew,
                                               input int i, input logic [63:0] x);
        logic [VW-1:0] m;
        m = VW'((ew == 64) ? '1 : ((64'd1 << ew) - 64'd1)) << (i*ew);
        return (v & ~m) | ((VW'(x) << (i*ew)) & m);
    endfunction

    function automatic logic [VW-1:0] fill(input int ew, input logic [63:0] x);
        logic [VW-1:0] v;
        v = '0;
        for (int i = 0; i < VW / ew; i++) v = set_lane(v, ew, i, x);
        return v;
    endfunction

    function automatic logic [VW/8-1:0] rnd_pred();
        logic [VW/8-1:0] p;
        for (int i = 0; i < VW / 8; i++) p[i] = ($urandom % 3) != 0;
        return p;
    endfunction

    task automatic check_out(input exp_t e);
        n_chk++;
        if (res !== e.res || inv !== e.inv || undef !== e.ud) begin
            n_bad++;
            $display("FAIL %s: res=%h inv=%b undef=%b expected res=%h inv=%b undef=%b",
                     e.tag, res, inv, undef, e.res, e.inv, e.ud);
        end
    endtask

    task automatic issue(input logic [VW-1:0] v, input logic [VW/8-1:0] p,
                         input logic [1:0] s, input logic d, input string tag);
        exp_t e;
        @(negedge clk);
        vec = v; pred = p; size = s; dn = d;
        ref_reduce(v, p, s, d, e.res, e.inv, e.ud);
        e.tag = tag;
        eq.push_back(e);
        #1;
        if (eq.size() > LAT) check_out(eq.pop_front());
    endtask

    initial begin
        logic [VW-1:0] v;
        exp_t r0;
        r0.res = 64'd0; r0.inv = 1'b0; r0.ud = 1'b0; r0.tag = "R12";
        repeat (3) @(negedge clk);
        vec = '1; pred = '1; size = 2'd1;
        #1;
        check_out(r0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 first result after reset is the fill value until the pipe fills
        issue(rnd_vec(32), '1, 2'd0, 1'b0, "R4");
        issue(rnd_vec(16), '0, 2'd1, 1'b0, "R2");
        issue(rnd_vec(32), '0, 2'd2, 1'b1, "R2");
        issue(rnd_vec(64), '0, 2'd3, 1'b0, "R2");
        issue(rnd_vec(32), {8{4'b1110}}, 2'd2, 1'b0, "R9");
        v = rnd_vec(32);
        issue(v, {8{4'b0001}}, 2'd2, 1'b0, "R9");
        issue(v, '1, 2'd2, 1'b0, "R9");
        issue(fill(16, 64'h3C00) | 256'h4500, '1, 2'd1, 1'b0, "R3");
        issue(set_lane(fill(32, 64'h7FC0_0001), 32, 5, 64'hC000_0000), '1, 2'd2, 1'b0, "R5");
        issue(set_lane(fill(16, 64'h8000), 16, 9, 64'h0000), '1, 2'd1, 1'b0, "R6");
        issue(fill(16, 64'h8000), '1, 2'd1, 1'b0, "R6");
        v = '0;
        v = set_lane(v, 64, 0, 64'h7FF0_0000_0000_0005);
        v = set_lane(v, 64, 1, 64'h7FF8_0000_0000_0001);
        v = set_lane(v, 64, 2, 64'h7FF8_0000_0000_0002);
        v = set_lane(v, 64, 3, 64'h7FF8_0000_0000_0003);
        issue(v, '1, 2'd3, 1'b0, "R7");
        issue(v, '1, 2'd3, 1'b1, "R7");
        v = set_lane(fill(32, 64'h0), 32, 0, 64'h7FC0_00AA);
        v = set_lane(v, 32, 1, 64'h7FC0_00BB);
        issue(v, 32'h0000_0011, 2'd2, 1'b0, "R8");
        issue(v, 32'h0000_0011, 2'd2, 1'b1, "R8");
        v = '0;
        v = set_lane(v, 64, 0, 64'h7FF8_0000_0000_0011);
        v = set_lane(v, 64, 1, 64'h7FF8_0000_0000_0022);
        v = set_lane(v, 64, 2, 64'h7FF0_0000_0000_0033);
        v = set_lane(v, 64, 3, 64'h3FF0_0000_0000_0000);
        issue(v, '1, 2'd3, 1'b0, "R1");
        v = fill(32, 64'h3F80_0000);
        v = set_lane(v, 32, 0, 64'h7F80_0001);
        v = set_lane(v, 32, 6, 64'h4040_0000);
        issue(v, '1, 2'd2, 1'b0, "R10");

        for (int i = 0; i < 150; i++) begin
            int ew;
            ew = 16 << ($urandom % 3);
            issue(rnd_vec(ew), rnd_pred(), (ew == 16) ? 2'd1 : (ew == 32) ? 2'd2 : 2'd3,
                  1'($urandom % 2), "R1");
        end
        for (int i = 0; i < 60; i++) begin
            logic [1:0] s;
            s = 2'($urandom % 4);
            issue(rnd_vec(16 << ((s == 0) ? 0 : (s - 1))), rnd_pred(), s, 1'($urandom % 2), "R11");
        end
        for (int i = 0; i < LAT; i++) issue('0, '0, 2'd3, 1'b0, "R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: res=%h inv=%b undef=%b expected completion", res, inv, undef);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule